// File: doc/BRIEF.md
# Comma word aligner

A deserializer hands over parallel words whose edges fall wherever the serial stream happened to be cut, not on symbol boundaries. This block watches that raw stream for a programmable alignment pattern (a comma), works out at which bit position the pattern starts, and then re-frames every following word on that boundary. The re-framed word leaves with the pattern in its least-significant bits. A sync flag reports that a boundary is held. A resynchronise pulse lets the surrounding protocol logic drop the boundary and hunt again.

Each cycle the block joins the previous raw word (low half) and the current raw word (high half) into a double-width window. It tests every word-width offset of that window at once, with bit 0 of the window taken as the earliest-received bit. Word width (10 or 8 bits), pattern length (10 or 7 bits) and match mode (exact only, or exact or complement) are plain control pins. They are meant to be held steady while a stream is running. The whole block runs on the recovered parallel clock.

The data path is a plain stream with no handshake. A word is taken on every rising edge and an aligned word is produced on every rising edge. The source cannot be stalled, so the block offers no back-pressure, and a consumer must accept one word per cycle.

Top module: `comma_word_aligner`

## Requirements
- R1: While `rst` is high at a rising edge, `aligned_out`, `pattern_hit`, `sync_ok` and `slip_offset` all become 0, and the stored previous word becomes 0. The block leaves reset searching.
- R2: `wide_mode`=1 selects 10-bit words (`data_in[9:0]`) and `wide_mode`=0 selects 8-bit words (`data_in[7:0]`; `data_in[9:8]` has no effect and `aligned_out[9:8]` reads 0). With word width N, the window is {current word, previous word}, and the previous word occupies window bits [N-1:0]. Offsets 0 to N-1 are tested every cycle.
- R3: `pat_long`=1 compares window bits [k+9:k] against `pattern[9:0]`. `pat_long`=0 compares window bits [k+6:k] against `pattern[6:0]`. An offset k is a candidate only if k+L is at most 2N, where L is the pattern length.
- R4: `match_either`=0 accepts only an exact match. `match_either`=1 also accepts the bitwise complement of the compared L pattern bits.
- R5: When several offsets in one window match, the lowest offset is taken.
- R6: While `sync_ok` is 0 and `resync` is low, a match at offset k in the window of edge n sets `slip_offset` to k and `sync_ok` to 1 at edge n+1. The word emitted at that edge carries the pattern in its low bits, and `pattern_hit` is 1 with it.
- R7: Let D(n) be the word sampled at edge n. After edge n+1, `aligned_out` equals bits [off+N-1:off] of {D(n), D(n-1)}, where off is the offset in force at edge n+1. This is the newly locked one when a lock happens at that edge. The latency is the same for every offset.
- R8: After edge n+1, `pattern_hit` is 1 exactly when the window of edge n matched (under R3 and R4) at the offset in force. The pattern or its complement then fills the low bits of `aligned_out`. In 8-bit mode with a 10-bit pattern, only the low 8 of those bits are visible.
- R9: While `sync_ok` is 1 and no `resync` arrives, `slip_offset` does not change. A pattern found at any other offset causes no `pattern_hit` and does not move the boundary.
- R10: A rising edge with `resync` high clears `sync_ok` and keeps `slip_offset`. No lock happens at that edge, and the search runs again from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered parallel clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 10 | Raw word from the deserializer, bit 0 earliest |
| pattern | input | 10 | Alignment pattern, bit 0 earliest |
| pat_long | input | 1 | 1: 10-bit pattern, 0: 7-bit pattern |
| wide_mode | input | 1 | 1: 10-bit words, 0: 8-bit words |
| match_either | input | 1 | 0: exact only, 1: exact or complement |
| resync | input | 1 | Drop the boundary and search again |
| aligned_out | output | 10 | Word re-framed on the detected boundary |
| pattern_hit | output | 1 | Pattern sits at the low end of this output word |
| sync_ok | output | 1 | A boundary is locked |
| slip_offset | output | 4 | Bit offset of the boundary in the window |

## Verification
Every result of this block is due exactly one rising edge after the edge that samples the second of the two words forming its window. This holds for the aligned word, the hit flag, the lock and the offset alike, and it does not depend on the offset. The bench drives each word at a falling edge and lets one rising edge pass, so its reference state covers the two register stages. It compares all four outputs at the next falling edge, and a resync pulse is applied on the same edge as the word it accompanies. The directed streams place commas at known stream bit positions, so the expected lock offset follows from simple arithmetic on those positions.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;
  parameter int unsigned WORD_W   = 10;
  parameter int unsigned NARROW_W = 8;
  parameter int unsigned LONG_L   = 10;
  parameter int unsigned SHORT_L  = 7;

  typedef enum logic {
    CMP_EXACT  = 1'b0,
    CMP_EITHER = 1'b1
  } cmp_mode_e;
endpackage

// File: rtl/comma_window_match.sv
// Stage 0: forms the two-word window and tests every offset in one cycle.
module comma_window_match
  import comma_align_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned NW = NARROW_W,
  parameter int unsigned LL = LONG_L,
  parameter int unsigned LS = SHORT_L,
  localparam int unsigned WIN = 2 * W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   data_in,
  input  logic [LL-1:0]  pattern,
  input  logic           pat_long,
  input  logic           wide_mode,
  input  logic           match_either,
  output logic [WIN-1:0] win_q,
  output logic [W-1:0]   match_q,
  output logic           wide_q
);
  logic [W-1:0]      hist_q;
  logic [WIN-1:0]    win_c;
  logic [WIN+LL-1:0] win_ext;
  logic [W-1:0]      hit_c;
  cmp_mode_e         mode;

  assign mode = cmp_mode_e'(match_either);

  always_comb begin
    if (wide_mode) win_c = {data_in, hist_q};
    else           win_c = {{(WIN-2*NW){1'b0}}, data_in[NW-1:0], hist_q[NW-1:0]};
  end

  assign win_ext = {{LL{1'b0}}, win_c};

  for (genvar k = 0; k < W; k++) begin : g_pos
    localparam bit FIT_WL = (k + LL <= 2 * W);
    localparam bit FIT_WS = (k + LS <= 2 * W);
    localparam bit FIT_NL = (k < NW) && (k + LL <= 2 * NW);
    localparam bit FIT_NS = (k < NW) && (k + LS <= 2 * NW);
    logic [LL-1:0] cand;
    logic fit, same, inv;
    assign cand = win_ext[k +: LL];
    always_comb begin
      if (wide_mode) fit = pat_long ? FIT_WL : FIT_WS;
      else           fit = pat_long ? FIT_NL : FIT_NS;
      if (pat_long) begin
        same = (cand == pattern);
        inv  = (cand == ~pattern);
      end else begin
        same = (cand[LS-1:0] == pattern[LS-1:0]);
        inv  = (cand[LS-1:0] == ~pattern[LS-1:0]);
      end
    end
    assign hit_c[k] = fit && (same || ((mode == CMP_EITHER) && inv));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q  <= '0;
      win_q   <= '0;
      match_q <= '0;
      wide_q  <= 1'b1;
    end else begin
      hist_q  <= data_in;
      win_q   <= win_c;
      match_q <= hit_c;
      wide_q  <= wide_mode;
    end
  end

  AST_NARROW_NO_HIGH_HIT: assert property (@(posedge clk) disable iff (rst)
    !wide_q |-> ((match_q >> NW) == '0)); // R2
endmodule

// File: rtl/comma_first_hit.sv
// Lowest-position priority pick over the match vector.
module comma_first_hit #(
  parameter int unsigned W = comma_align_pkg::WORD_W,
  localparam int unsigned OW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [OW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = OW'(i);
    end
  end
endmodule

// File: rtl/comma_align_ctrl.sv
// Stage 1: lock control and the barrel shift onto the held boundary.
module comma_align_ctrl #(
  parameter int unsigned W  = comma_align_pkg::WORD_W,
  parameter int unsigned NW = comma_align_pkg::NARROW_W,
  localparam int unsigned OW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2*W-1:0] win_q,
  input  logic [W-1:0]  match_q,
  input  logic          wide_q,
  input  logic          any,
  input  logic [OW-1:0] first_idx,
  input  logic          resync,
  output logic [W-1:0]  aligned_q,
  output logic          hit_q,
  output logic          sync_q,
  output logic [OW-1:0] off_q
);
  logic          lock_now;
  logic [OW-1:0] eff;
  logic [W-1:0]  sh;
  logic [W-1:0]  aligned_n;

  assign lock_now = !sync_q && any && !resync;
  assign eff      = lock_now ? first_idx : off_q;
  assign sh       = W'(win_q >> eff);

  always_comb begin
    if (wide_q) aligned_n = sh;
    else        aligned_n = {{(W-NW){1'b0}}, sh[NW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aligned_q <= '0;
      hit_q     <= 1'b0;
      sync_q    <= 1'b0;
      off_q     <= '0;
    end else begin
      aligned_q <= aligned_n;
      hit_q     <= match_q[eff];
      if (resync) begin
        sync_q <= 1'b0;
      end else if (lock_now) begin
        sync_q <= 1'b1;
        off_q  <= first_idx;
      end
    end
  end

  AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (rst)
    (sync_q && !resync) |=> (sync_q && $stable(off_q))); // R9
  AST_RESYNC_DROP: assert property (@(posedge clk) disable iff (rst)
    resync |=> (!sync_q && $stable(off_q))); // R10
  AST_LOCK_SHOWS_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_q) |-> hit_q); // R6
  AST_OFF_IN_WORD: assert property (@(posedge clk) disable iff (rst)
    sync_q |-> (32'(off_q) < W)); // R2
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int unsigned W  = comma_align_pkg::WORD_W,
  parameter int unsigned NW = comma_align_pkg::NARROW_W,
  parameter int unsigned LL = comma_align_pkg::LONG_L,
  parameter int unsigned LS = comma_align_pkg::SHORT_L,
  localparam int unsigned OW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  data_in,
  input  logic [LL-1:0] pattern,
  input  logic          pat_long,
  input  logic          wide_mode,
  input  logic          match_either,
  input  logic          resync,
  output logic [W-1:0]  aligned_out,
  output logic          pattern_hit,
  output logic          sync_ok,
  output logic [OW-1:0] slip_offset
);
  logic [2*W-1:0] win_q;
  logic [W-1:0]   match_q;
  logic           wide_q;
  logic           any;
  logic [OW-1:0]  first_idx;

  comma_window_match #(.W(W), .NW(NW), .LL(LL), .LS(LS)) u_match (
    .clk(clk), .rst(rst), .data_in(data_in), .pattern(pattern),
    .pat_long(pat_long), .wide_mode(wide_mode), .match_either(match_either),
    .win_q(win_q), .match_q(match_q), .wide_q(wide_q)
  );

  comma_first_hit #(.W(W)) u_pick (
    .vec(match_q), .any(any), .idx(first_idx)
  );

  comma_align_ctrl #(.W(W), .NW(NW)) u_ctrl (
    .clk(clk), .rst(rst), .win_q(win_q), .match_q(match_q), .wide_q(wide_q),
    .any(any), .first_idx(first_idx), .resync(resync),
    .aligned_q(aligned_out), .hit_q(pattern_hit), .sync_q(sync_ok),
    .off_q(slip_offset)
  );

  function automatic logic [W-1:0] low_mask(input logic lng, input logic wde);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) begin
      m[i] = (i < int'(lng ? LL : LS)) && (i < int'(wde ? W : NW));
    end
    return m;
  endfunction

  AST_HIT_AT_LSB: assert property (@(posedge clk) disable iff (rst)
    pattern_hit |->
      ((((aligned_out ^ W'($past(pattern, 2))) &
         low_mask($past(pat_long, 2), $past(wide_mode, 2))) == '0) ||
       ($past(match_either, 2) &&
        (((aligned_out ^ ~W'($past(pattern, 2))) &
          low_mask($past(pat_long, 2), $past(wide_mode, 2))) == '0)))); // R8
endmodule

// File: tb/comma_word_aligner_test.sv
module comma_word_aligner_test;
  localparam logic [9:0] K = 10'b0011111010;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] data_in = '0;
  logic [9:0] pattern = K;
  logic       pat_long = 1'b1;
  logic       wide_mode = 1'b1;
  logic       match_either = 1'b0;
  logic       resync = 1'b0;
  logic [9:0] aligned_out;
  logic       pattern_hit;
  logic       sync_ok;
  logic [3:0] slip_offset;

  always #4 clk = ~clk;

  comma_word_aligner uut (
    .clk(clk), .rst(rst), .data_in(data_in), .pattern(pattern),
    .pat_long(pat_long), .wide_mode(wide_mode), .match_either(match_either),
    .resync(resync), .aligned_out(aligned_out), .pattern_hit(pattern_hit),
    .sync_ok(sync_ok), .slip_offset(slip_offset)
  );

  int checks = 0;
  int fails = 0;
  int hits = 0;
  bit done = 0;

  logic sb [0:16383];
  int sb_w = 0;
  int sb_r = 0;

  logic [9:0]  m_hist = '0;
  logic [19:0] m_win = '0;
  logic [9:0]  m_match = '0;
  logic        m_wideq = 1'b1;
  logic        m_sync = 1'b0;
  logic [3:0]  m_off = '0;
  logic [9:0]  m_out = '0;
  logic        m_det = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] ref_match(input logic [19:0] win, input logic wd,
                                           input logic lg, input logic ei,
                                           input logic [9:0] pat);
    logic [9:0] v;
    logic [9:0] cand;
    logic [9:0] mask;
    int n;
    int l;
    n = wd ? 10 : 8;
    l = lg ? 10 : 7;
    mask = lg ? 10'h3FF : 10'h07F;
    v = '0;
    for (int k = 0; k < 10; k++) begin
      cand = 10'(win >> k);
      if (k < n && k + l <= 2 * n) begin
        v[k] = (((cand ^ pat) & mask) == '0) ||
               (ei && (((cand ^ ~pat) & mask) == '0));
      end
    end
    return v;
  endfunction

  task automatic model_edge(input logic [9:0] d, input logic rs);
    logic lock;
    logic [3:0] first;
    logic [3:0] eff;
    logic [19:0] sh;
    first = '0;
    for (int i = 9; i >= 0; i--) if (m_match[i]) first = 4'(i);
    lock = !m_sync && (m_match != '0) && !rs;
    eff = lock ? first : m_off;
    sh = m_win >> eff;
    m_out = m_wideq ? sh[9:0] : {2'b00, sh[7:0]};
    m_det = m_match[eff];
    if (rs) m_sync = 1'b0;
    else if (lock) begin
      m_sync = 1'b1;
      m_off = first;
    end
    m_win = wide_mode ? {d, m_hist} : {4'b0, d[7:0], m_hist[7:0]};
    m_match = ref_match(m_win, wide_mode, pat_long, match_either, pattern);
    m_wideq = wide_mode;
    m_hist = d;
  endtask

  task automatic cyc(input logic [9:0] d, input logic rs);
    data_in = d;
    resync = rs;
    @(posedge clk);
    model_edge(d, rs);
    @(negedge clk);
    check(aligned_out == m_out, "R7", "aligned_out", aligned_out, m_out);
    check(pattern_hit == m_det, "R8", "pattern_hit", pattern_hit, m_det);
    check(sync_ok == m_sync, "R6", "sync_ok", sync_ok, m_sync);
    check(slip_offset == m_off, "R5", "slip_offset", slip_offset, m_off);
    if (pattern_hit) hits++;
    resync = 1'b0;
  endtask

  task automatic put(input logic [9:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sb[sb_w] = v[i];
      sb_w++;
    end
  endtask

  task automatic put_zero(input int n);
    put_bits_const(1'b0, n);
  endtask

  task automatic put_bits_const(input logic b, input int n);
    for (int i = 0; i < n; i++) begin
      sb[sb_w] = b;
      sb_w++;
    end
  endtask

  task automatic put_rand(input int n);
    for (int i = 0; i < n; i++) begin
      sb[sb_w] = 1'($urandom);
      sb_w++;
    end
  endtask

  task automatic feed(input bit rs_first);
    int n;
    bit rs;
    n = wide_mode ? 10 : 8;
    rs = rs_first;
    while (sb_r + n <= sb_w) begin
      logic [9:0] w;
      w = 10'($urandom);
      for (int i = 0; i < n; i++) w[i] = sb[sb_r + i];
      sb_r += n;
      cyc(w, rs);
      rs = 1'b0;
    end
    sb_r = 0;
    sb_w = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(aligned_out == '0, "R1", "aligned_out after reset", aligned_out, 0);
    check(pattern_hit == 1'b0, "R1", "pattern_hit after reset", pattern_hit, 0);
    check(sync_ok == 1'b0, "R1", "sync_ok after reset", sync_ok, 0);
    check(slip_offset == '0, "R1", "slip_offset after reset", slip_offset, 0);
    rst = 1'b0;

    // R6: 10-bit exact comma starting at stream bit 23 -> offset 3
    put_zero(23); put(K, 10); put_zero(47);
    hits = 0;
    feed(0);
    check(sync_ok == 1'b1, "R6", "locked on comma", sync_ok, 1);
    check(slip_offset == 4'd3, "R6", "lock offset", slip_offset, 3);
    check(hits == 1, "R8", "hit count", hits, 1);

    // R9: comma at offset 6 while locked at 3
    put_zero(6); put(K, 10); put_zero(44);
    hits = 0;
    feed(0);
    check(slip_offset == 4'd3, "R9", "offset held", slip_offset, 3);
    check(sync_ok == 1'b1, "R9", "still locked", sync_ok, 1);
    check(hits == 0, "R9", "foreign comma hits", hits, 0);

    // R10: resync then relock at offset 6
    put_zero(10); put_zero(6); put(K, 10); put_zero(44);
    feed(1);
    check(slip_offset == 4'd6, "R10", "relock offset", slip_offset, 6);
    check(sync_ok == 1'b1, "R10", "relocked", sync_ok, 1);

    // R4: complement ignored in exact mode, accepted in either mode
    put_zero(10); put_zero(2); put(~K, 10); put_zero(48);
    feed(1);
    check(sync_ok == 1'b0, "R4", "complement in exact mode", sync_ok, 0);
    check(slip_offset == 4'd6, "R10", "offset kept across resync", slip_offset, 6);
    match_either = 1'b1;
    put_zero(2); put(~K, 10); put_zero(48);
    feed(0);
    check(sync_ok == 1'b1, "R4", "complement in either mode", sync_ok, 1);
    check(slip_offset == 4'd2, "R4", "complement offset", slip_offset, 2);

    // R5: two 7-bit patterns at offsets 1 and 8, lowest wins
    match_either = 1'b0;
    pat_long = 1'b0;
    put_zero(10); put_zero(1); put(K, 7); put(K, 7); put_zero(45);
    feed(1);
    check(slip_offset == 4'd1, "R5", "lowest offset wins", slip_offset, 1);
    check(sync_ok == 1'b1, "R5", "locked on first", sync_ok, 1);

    // R2: 8-bit words, 7-bit pattern at offset 5
    wide_mode = 1'b0;
    put_zero(8); put_zero(5); put(K, 7); put_zero(36);
    feed(1);
    check(slip_offset == 4'd5, "R2", "narrow offset", slip_offset, 5);
    check(aligned_out[9:8] == 2'b00, "R2", "narrow upper bits", aligned_out[9:8], 0);

    // R3: 10-bit pattern at offset 7 does not fit an 8-bit window
    pat_long = 1'b1;
    put_zero(8); put_zero(7); put(K, 10); put_zero(31);
    feed(1);
    check(sync_ok == 1'b0, "R3", "no fit at offset 7", sync_ok, 0);
    put_zero(4); put(K, 10); put_zero(34);
    feed(0);
    check(slip_offset == 4'd4, "R3", "fit at offset 4", slip_offset, 4);
    check(sync_ok == 1'b1, "R3", "locked at 4", sync_ok, 1);

    // random configurations and streams, reference model compared every cycle
    for (int blk = 0; blk < 40; blk++) begin
      int l;
      wide_mode = 1'($urandom);
      pat_long = 1'($urandom);
      match_either = 1'($urandom);
      pattern = ($urandom_range(0, 1) == 0) ? K : 10'($urandom);
      l = pat_long ? 10 : 7;
      put_rand(16);
      for (int j = 0; j < 8; j++) begin
        put_rand($urandom_range(0, 24));
        if ($urandom_range(0, 1) == 0) put(pattern, l);
        else put(~pattern, l);
      end
      put_rand(20);
      feed($urandom_range(0, 2) == 0);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end
endmodule